// File: doc/BRIEF.md
# Printer port register interface

This block is the host-side register front end of a classic byte-wide printer port. A bus master reaches three live registers through a 3-bit offset taken from the low bits of its address: a data register, a status register and a control register. Bytes written to the data register are held until software pulses the strobe bit in the control register. That pulse sends the held byte out once on a valid/byte stream that stands in for the cable. When the direction bit is set, a byte sampled from an input port can be read back instead.

No printer is attached, so the block plays the printer's part in the busy/acknowledge handshake itself. Each status read both returns the current status and moves a small scripted sequence one step forward. A driver that polls status after every strobe therefore sees busy drop, acknowledge pulse and busy return, and it finishes its handshake. Software can also enable an interrupt. The interrupt is raised when the strobe is released and cleared by the next status read.

Top module: `prn_port_regs`

## Requirements
- R1: The register offset is `bus_addr[2:0]`; higher address bits are ignored. Offset 0 is data, 1 is status, 2 is control. A read loads `bus_rdata` at the clock edge where `bus_rd` is sampled, and `bus_rdata` holds that value until the next read. A read of offsets 3 to 7 returns 0xFF.
- R2: After reset, `bus_rdata` is 0xFF, both the written data byte and the input latch are 0xFF, status is 0xD9, control is 0xCC, and `irq` and `out_valid` are 0.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1. A read of offset 2 returns the stored value. Control bit 5 selects direction, bit 4 enables the interrupt, bit 3 is select, bit 2 is init and bit 0 is strobe.
- R4: A data read returns the input latch when control bit 5 is 1, and the last written data byte when it is 0. The input latch samples `in_data` on every clock edge.
- R5: A control write with bit 2 at 0 sets status to 0xD8.
- R6: A control write with bits 2, 3 and 0 all at 1 clears status bit 7 (not-busy). If the stored strobe bit was 0 before that write, the next cycle carries a one-cycle `out_valid` pulse with `out_data` equal to the data byte.
- R7: A control write with bit 2 at 1, bit 3 at 1 and bit 0 at 0 sets the interrupt-pending flag when the control value stored before that write has bit 4 at 1. `irq` equals the pending flag.
- R8: A status read returns the status held before the read and clears the pending flag.
- R9: A status read taken while status bit 7 is 0 and control bit 0 is 0 changes the status after it is returned. If status bit 6 (acknowledge) is 1, that bit is cleared. Otherwise bits 6 and 7 are both set.
- R10: Writes to offset 1 and to offsets 3 to 7 change no state. When `bus_wr` and `bus_rd` are high together, the write takes effect and the read is ignored, so `bus_rdata` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address; the low three bits select the register |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| in_data | input | 8 | Byte sampled into the input latch |
| out_valid | output | 1 | One-cycle pulse when a byte is emitted |
| out_data | output | 8 | Emitted byte |
| irq | output | 1 | Interrupt request level |

## Verification
A wrong status or control value stays hidden until the next read of offset 1 or 2. That read shows it one cycle later. A wrong status also changes the steps of the handshake on every following status read. A missing or extra emission shows on `out_valid` in the cycle right after the strobe write. A bad interrupt-pending flag shows on `irq` at once, because `irq` is that flag. The bench exercises the order of the handshake: three status reads after a strobe must return not-busy cleared, then acknowledge cleared, then both set again.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int BYTE_W = 8;
  localparam int OFFS_W = 3;

  typedef enum logic [OFFS_W-1:0] {
    OFF_DATA = 3'd0,
    OFF_STAT = 3'd1,
    OFF_CTRL = 3'd2
  } prn_off_e;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;
  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [BYTE_W-1:0] CTRL_FORCE  = 8'hC0;
  localparam logic [BYTE_W-1:0] STAT_RST    = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT   = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST    = 8'hCC;
  localparam logic [BYTE_W-1:0] DATA_RST    = 8'hFF;
  localparam logic [BYTE_W-1:0] UNMAPPED_RD = 8'hFF;
endpackage

// File: rtl/prn_ctrl_reg.sv
module prn_ctrl_reg
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctl_q,
  output logic              emit_req
);
  logic [BYTE_W-1:0] ctl_nxt;

  always_comb begin
    ctl_nxt = wdata | CTRL_FORCE;
  end

  // strobe rising while init and select are high
  always_comb begin
    emit_req = ctl_we && ctl_nxt[CT_INIT] && ctl_nxt[CT_SEL]
               && ctl_nxt[CT_STB] && !ctl_q[CT_STB];
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= CTRL_RST;
    else if (ctl_we)
      ctl_q <= ctl_nxt;
  end
endmodule

// File: rtl/prn_status_seq.sv
module prn_status_seq
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] ctl_q,
  input  logic              sts_rd,
  output logic [BYTE_W-1:0] sts_q,
  output logic              pend_q
);
  logic [BYTE_W-1:0] sts_nxt;
  logic              pend_nxt;

  always_comb begin
    sts_nxt  = sts_q;
    pend_nxt = pend_q;
    if (ctl_we) begin
      if (!wdata[CT_INIT]) begin
        sts_nxt = STAT_INIT;
      end else if (wdata[CT_SEL]) begin
        if (wdata[CT_STB])
          sts_nxt[ST_NBUSY] = 1'b0;
        else if (ctl_q[CT_IEN])
          pend_nxt = 1'b1;
      end
    end else if (sts_rd) begin
      pend_nxt = 1'b0;
      if (!sts_q[ST_NBUSY] && !ctl_q[CT_STB]) begin
        if (sts_q[ST_ACK]) begin
          sts_nxt[ST_ACK] = 1'b0;
        end else begin
          sts_nxt[ST_ACK]   = 1'b1;
          sts_nxt[ST_NBUSY] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= STAT_RST;
      pend_q <= 1'b0;
    end else begin
      sts_q  <= sts_nxt;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/prn_data_path.sv
module prn_data_path
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              emit_req,
  output logic [BYTE_W-1:0] dw_q,
  output logic [BYTE_W-1:0] lat_q,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dw_q      <= DATA_RST;
      lat_q     <= DATA_RST;
      out_valid <= 1'b0;
      out_data  <= DATA_RST;
    end else begin
      lat_q     <= in_data;
      out_valid <= emit_req;
      if (dat_we)
        dw_q <= wdata;
      if (emit_req)
        out_data <= dw_q;
    end
  end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              irq
);
  logic [OFFS_W-1:0] offs;
  logic              ctl_we, dat_we, sts_rd, rd_eff;
  logic [BYTE_W-1:0] ctl_w, sts_w, dw_w, lat_w, rd_mux;
  logic              emit_w, pend_w;

  generate
    if (ADDR_W > OFFS_W) begin : g_wide
      assign offs = bus_addr[OFFS_W-1:0];
    end else begin : g_narrow
      assign offs = OFFS_W'(bus_addr);
    end
  endgenerate

  assign rd_eff = bus_rd && !bus_wr;
  assign ctl_we = bus_wr && (offs == OFF_CTRL);
  assign dat_we = bus_wr && (offs == OFF_DATA);
  assign sts_rd = rd_eff && (offs == OFF_STAT);

  prn_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .wdata(bus_wdata),
    .ctl_q(ctl_w), .emit_req(emit_w)
  );

  prn_status_seq u_stat (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .wdata(bus_wdata),
    .ctl_q(ctl_w), .sts_rd(sts_rd), .sts_q(sts_w), .pend_q(pend_w)
  );

  prn_data_path u_data (
    .clk(clk), .rst(rst), .dat_we(dat_we), .wdata(bus_wdata),
    .in_data(in_data), .emit_req(emit_w), .dw_q(dw_w), .lat_q(lat_w),
    .out_valid(out_valid), .out_data(out_data)
  );

  always_comb begin
    case (offs)
      OFF_DATA: rd_mux = ctl_w[CT_DIR] ? lat_w : dw_w;
      OFF_STAT: rd_mux = sts_w;
      OFF_CTRL: rd_mux = ctl_w;
      default:  rd_mux = UNMAPPED_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= UNMAPPED_RD;
    else if (rd_eff)
      bus_rdata <= rd_mux;
  end

  assign irq = pend_w;
endmodule

// File: rtl/prn_port_regs_chk.sv
module prn_port_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              out_valid,
  input logic              irq,
  input logic [7:0]        sts
);
  // R1
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr[2:0] > 3'd2) |=> bus_rdata == 8'hFF);
  // R3
  ctrl_high_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr[2:0] == 3'd2) |=> bus_rdata[7:6] == 2'b11);
  // R5
  init_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[2:0] == 3'd2 && !bus_wdata[2]) |=> sts == 8'hD8);
  // R6
  single_emit_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R6
  emit_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !sts[7]);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr[2:0] == 3'd1) |=> !irq);
  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(bus_wr && bus_addr[2:0] == 3'd2));
endmodule

bind prn_port_regs prn_port_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .out_valid(out_valid), .irq(irq), .sts(sts_w)
);

// File: tb/test_prn_port_regs.sv
`timescale 1ns/1ps
module test_prn_port_regs;
  localparam int AW = 8;
  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] bus_addr;
  logic bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, in_data, out_data;
  logic out_valid, irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R2";

  // behavioural reference state
  int m_dw, m_lat, m_st, m_ctl, m_pend, m_rdata, m_valid, m_odata;

  always #10 clk = ~clk;

  prn_port_regs #(.ADDR_W(AW)) i_prn_port_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dw = 8'hFF; m_lat = 8'hFF; m_st = 8'hD9; m_ctl = 8'hCC;
    m_pend = 0; m_rdata = 8'hFF; m_valid = 0; m_odata = 8'hFF;
  endtask

  task automatic model_step(input int off, input bit wr, input bit rd, input int wd, input int ind);
    int v;
    m_valid = 0;
    if (wr) begin
      if (off == 0) m_dw = wd;
      else if (off == 2) begin
        v = wd | 8'hC0;
        if ((v & 8'h04) == 0) m_st = 8'hD8;
        else if ((v & 8'h08) != 0) begin
          if ((v & 8'h01) != 0) begin
            m_st = m_st & 8'h7F;
            if ((m_ctl & 8'h01) == 0) begin m_valid = 1; m_odata = m_dw; end
          end else if ((m_ctl & 8'h10) != 0) m_pend = 1;
        end
        m_ctl = v;
      end
    end else if (rd) begin
      case (off)
        0: m_rdata = ((m_ctl & 8'h20) != 0) ? m_lat : m_dw;
        1: begin
          m_rdata = m_st;
          m_pend = 0;
          if ((m_st & 8'h80) == 0 && (m_ctl & 8'h01) == 0) begin
            if ((m_st & 8'h40) != 0) m_st = m_st & 8'hBF;
            else m_st = m_st | 8'hC0;
          end
        end
        2: m_rdata = m_ctl;
        default: m_rdata = 8'hFF;
      endcase
    end
    m_lat = ind;
  endtask

  task automatic compare();
    chk(cur_req, "bus_rdata", int'(bus_rdata), m_rdata);
    chk(cur_req, "irq", int'(irq), m_pend);
    chk(cur_req, "out_valid", int'(out_valid), m_valid);
    if (m_valid != 0) chk(cur_req, "out_data", int'(out_data), m_odata);
  endtask

  task automatic cyc(input int addr, input bit wr, input bit rd, input int wd, input int ind);
    @(negedge clk);
    bus_addr = AW'(addr); bus_wr = wr; bus_rd = rd;
    bus_wdata = 8'(wd); in_data = 8'(ind);
    @(posedge clk);
    model_step(addr & 7, wr, rd, wd, ind);
    @(negedge clk);
    compare();
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr_reg(input int addr, input int wd);
    cyc(addr, 1'b1, 1'b0, wd, 8'h00);
  endtask

  task automatic rd_reg(input int addr, input int ind);
    cyc(addr, 1'b0, 1'b1, 8'h00, ind);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; in_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R2 reset state at the ports
    cur_req = "R2";
    compare();
    rd_reg(0, 0); rd_reg(1, 0); rd_reg(2, 0);
    // R1 unmapped offsets and address aliasing
    cur_req = "R1";
    for (int o = 3; o < 8; o++) rd_reg(o, 0);
    rd_reg(8'hF9, 0);
    // R3 control forced bits
    cur_req = "R3";
    wr_reg(2, 8'h05); rd_reg(2, 0);
    wr_reg(8'hA2, 8'h0C); rd_reg(2, 0);
    // R4 data direction
    cur_req = "R4";
    wr_reg(0, 8'h3C); rd_reg(0, 8'h11);
    wr_reg(2, 8'h2C); cyc(0, 0, 0, 0, 8'hA5); rd_reg(0, 8'h5A); rd_reg(0, 8'h00);
    wr_reg(2, 8'h0C); rd_reg(0, 0);
    // R5 init load
    cur_req = "R5";
    wr_reg(2, 8'h08); rd_reg(1, 0);
    // R6 emission on strobe rise, only once
    cur_req = "R6";
    wr_reg(2, 8'h0C); wr_reg(0, 8'h41); wr_reg(2, 8'h0D);
    wr_reg(2, 8'h0D); rd_reg(1, 0);
    // R9 handshake sequence
    cur_req = "R9";
    wr_reg(2, 8'h0C);
    rd_reg(1, 0); rd_reg(1, 0); rd_reg(1, 0); rd_reg(1, 0);
    // R7 interrupt pending on strobe release with enable
    cur_req = "R7";
    wr_reg(2, 8'h1C); wr_reg(0, 8'h7E); wr_reg(2, 8'h1D); wr_reg(2, 8'h1C);
    chk("R7", "irq raised", int'(irq), 1);
    // R8 status read clears
    cur_req = "R8";
    rd_reg(1, 0);
    chk("R8", "irq cleared", int'(irq), 0);
    // R10 ignored writes and write priority
    cur_req = "R10";
    wr_reg(1, 8'hFF); wr_reg(5, 8'h00); wr_reg(7, 8'h00); rd_reg(1, 0); rd_reg(2, 0);
    cyc(0, 1'b1, 1'b1, 8'h99, 0);
    chk("R10", "rdata held", int'(bus_rdata), m_rdata);
    rd_reg(0, 0);
    // R6 again from a different data byte
    cur_req = "R6";
    wr_reg(2, 8'h0C); wr_reg(0, 8'hC3); wr_reg(2, 8'h0D); cyc(0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule